// File: doc/BRIEF.md
# Windowed Vertical Sync Divider

This block derives the vertical reset of a television scan from a counter that advances on a clock enable pulsing at twice the horizontal line rate. The counter locks to separated vertical sync pulses. It works out whether the incoming field rate is 50 Hz or 60 Hz from where in the count the sync arrives. When there is no signal it keeps the vertical drive running on its own.

A saturating up/down confidence count records how often sync pulses land where a standard field would put them. It moves the block between two modes. In the wide search mode any sync late enough in the field is accepted. In the narrow lock mode only a few counts around the expected field length are accepted, and a missing pulse is replaced by a reset generated inside the block. The two mode changes use different thresholds, which gives hysteresis.

The block also drives a flutter-blanking pulse that holds off the horizontal phase detector around vertical sync. In wide mode this pulse starts at the divider reset. In lock mode it starts a little ahead of the window. In both modes it ends at a count that depends on the field rate.

Top module: `vsync_divider`

## Requirements
- R1: After reset the strobe, the 60 Hz flag, the lock flag and the blanking pulse are 0, the confidence count is 0, and the first tick sees count 1.
- R2: In wide mode a sync event seen at count 488 or later resets the divider: the next tick sees count 1 and the strobe goes high. A sync event at a lower count is ignored.
- R3: A sync event accepted in wide mode sets the 60 Hz flag when the count was below 576 and clears it otherwise. The flag changes at no other time.
- R4: In wide mode, if no sync event has been accepted by count 630, the divider resets itself at count 630.
- R5: The confidence count changes by one, saturating at 0 and 15, only at a divider reset. It rises when the accepted pulse lies in a lock window and falls otherwise. In wide mode either standard's window counts. A self-generated reset always lowers it.
- R6: Lock mode is entered when the confidence count becomes 15. Lock mode is left when it drops below 10, and is kept from 10 to 14.
- R7: In lock mode the window is counts 522 to 528 when the 60 Hz flag is 1 and counts 622 to 628 otherwise. A sync event inside the window resets the divider. A sync event outside it is ignored.
- R8: In lock mode, when no sync event arrives by the last window count, the divider resets at that count and the confidence count falls by one.
- R9: The blanking pulse rises with the strobe of a wide-mode reset. In lock mode it rises at the window start minus 3 (count 519 or 619).
- R10: The blanking pulse falls on the tick that sees count 10 when the 60 Hz flag is 0, and count 12 when it is 1.
- R11: The strobe lasts exactly one tick period. No output changes on a clock edge without a tick.
- R12: A sync event is the first tick on which the sync input is high after a tick on which it was low. A level held high counts once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Clock enable at twice the line rate |
| vsync | input | 1 | Separated vertical sync level |
| vreset | output | 1 | Vertical reset strobe, one tick period long |
| field_60 | output | 1 | 1 when a 60 Hz field rate was detected |
| lock_narrow | output | 1 | 1 in narrow lock mode |
| flutter_blank | output | 1 | Phase-detector blanking pulse |
| confidence | output | 4 | Confidence count |

## Verification
The sync input is driven with no signal at all, and with standard 625-count and 525-count fields, until lock is reached in each standard. These runs separate free-running behaviour from tracking, and show both standards' blanking lengths in both modes. In lock mode, fields with sync outside the window and with sync missing are used to show the window-end reset and the hysteresis before lock is lost. In wide mode, off-standard periods on either side of count 576, an early pulse and a level held high across the acceptance point tell rate detection, the lower acceptance bound and edge qualification apart. A long run of off-window fields shows the confidence count saturating at zero.

// File: rtl/vsd_pkg.sv
package vsd_pkg;

   typedef enum logic {
      WIN_WIDE   = 1'b0,
      WIN_NARROW = 1'b1
   } win_e;

   // inclusive range test on zero-extended counts
   function automatic logic in_span(input logic [15:0] v,
                                    input logic [15:0] lo,
                                    input logic [15:0] hi);
      return (v >= lo) && (v <= hi);
   endfunction

endpackage

// File: rtl/vsd_window_decode.sv
module vsd_window_decode
   import vsd_pkg::*;
#(
   parameter int unsigned WIDE_LO    = 488,
   parameter int unsigned FREE_RUN   = 630,
   parameter int unsigned N60_LO     = 522,
   parameter int unsigned N60_HI     = 528,
   parameter int unsigned N50_LO     = 622,
   parameter int unsigned N50_HI     = 628,
   parameter int unsigned EQ_OFFSET  = 3,
   parameter int unsigned ATF_END_50 = 10,
   parameter int unsigned ATF_END_60 = 12,
   parameter int unsigned CNT_W      = 10
) (
   input  logic [CNT_W-1:0] cnt,
   input  logic             narrow,
   input  logic             field_60,
   output logic             wide_ok,
   output logic             in_lock,
   output logic             win_end,
   output logic             eq_hit,
   output logic             atf_end_hit
);

   logic [15:0] c16;
   logic [15:0] lo_sel;
   logic [15:0] hi_sel;
   logic [15:0] end_sel;
   logic        in_any;

   assign c16 = 16'(cnt);

   always_comb begin
      lo_sel  = field_60 ? 16'(N60_LO)     : 16'(N50_LO);
      hi_sel  = field_60 ? 16'(N60_HI)     : 16'(N50_HI);
      end_sel = field_60 ? 16'(ATF_END_60) : 16'(ATF_END_50);
   end

   assign in_any = in_span(c16, 16'(N60_LO), 16'(N60_HI)) ||
                   in_span(c16, 16'(N50_LO), 16'(N50_HI));

   always_comb begin
      wide_ok     = c16 >= 16'(WIDE_LO);
      in_lock     = narrow ? in_span(c16, lo_sel, hi_sel) : in_any;
      win_end     = narrow ? (c16 == hi_sel) : (c16 >= 16'(FREE_RUN));
      eq_hit      = c16 == (lo_sel - 16'(EQ_OFFSET));
      atf_end_hit = c16 == end_sel;
   end

endmodule

// File: rtl/vsd_confidence.sv
module vsd_confidence
   import vsd_pkg::*;
#(
   parameter int unsigned CONF_MAX     = 15,
   parameter int unsigned UNLOCK_BELOW = 10,
   parameter int unsigned CONF_W       = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              up,
   input  logic              down,
   output logic [CONF_W-1:0] conf,
   output logic              lock
);

   localparam logic [CONF_W-1:0] TOP  = CONF_W'(CONF_MAX);
   localparam logic [CONF_W-1:0] ONE  = CONF_W'(1);
   localparam logic [CONF_W-1:0] DROP = CONF_W'(UNLOCK_BELOW);

   logic [CONF_W-1:0] conf_q, conf_nx;
   win_e              mode_q, mode_nx;

   always_comb begin
      conf_nx = conf_q;
      if (up && (conf_q != TOP))
         conf_nx = conf_q + ONE;
      else if (down && (conf_q != '0))
         conf_nx = conf_q - ONE;
   end

   always_comb begin
      mode_nx = mode_q;
      unique case (mode_q)
         WIN_WIDE:   if (conf_nx == TOP) mode_nx = WIN_NARROW;
         WIN_NARROW: if (conf_nx < DROP) mode_nx = WIN_WIDE;
         default:    mode_nx = WIN_WIDE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         conf_q <= '0;
         mode_q <= WIN_WIDE;
      end else begin
         conf_q <= conf_nx;
         mode_q <= mode_nx;
      end
   end

   assign conf = conf_q;
   assign lock = (mode_q == WIN_NARROW);

endmodule

// File: rtl/vsd_flutter.sv
module vsd_flutter (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic stop,
   output logic blank
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         blank <= 1'b0;
      else if (start)
         blank <= 1'b1;
      else if (stop)
         blank <= 1'b0;
   end

endmodule

// File: rtl/vsync_divider.sv
module vsync_divider #(
   parameter int unsigned WIDE_LO      = 488,
   parameter int unsigned MODE_SPLIT   = 576,
   parameter int unsigned FREE_RUN     = 630,
   parameter int unsigned N60_LO       = 522,
   parameter int unsigned N60_HI       = 528,
   parameter int unsigned N50_LO       = 622,
   parameter int unsigned N50_HI       = 628,
   parameter int unsigned EQ_OFFSET    = 3,
   parameter int unsigned ATF_END_50   = 10,
   parameter int unsigned ATF_END_60   = 12,
   parameter int unsigned CONF_MAX     = 15,
   parameter int unsigned UNLOCK_BELOW = 10,
   parameter int unsigned SYNC_EDGE    = 1,
   localparam int unsigned CNT_W       = $clog2(FREE_RUN + 1),
   localparam int unsigned CONF_W      = $clog2(CONF_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              vsync,
   output logic              vreset,
   output logic              field_60,
   output logic              lock_narrow,
   output logic              flutter_blank,
   output logic [CONF_W-1:0] confidence
);

   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
   localparam logic [CNT_W-1:0] SPLIT   = CNT_W'(MODE_SPLIT);

   // elaboration-time parameter checks
   if (!(WIDE_LO < MODE_SPLIT && MODE_SPLIT < FREE_RUN)) begin : g_bad_wide
      $error("vsync_divider: need WIDE_LO < MODE_SPLIT < FREE_RUN");
   end
   if (!(N60_LO <= N60_HI && N60_HI < MODE_SPLIT)) begin : g_bad_n60
      $error("vsync_divider: 60 Hz window must lie below MODE_SPLIT");
   end
   if (!(MODE_SPLIT <= N50_LO && N50_LO <= N50_HI && N50_HI <= FREE_RUN)) begin : g_bad_n50
      $error("vsync_divider: 50 Hz window must lie in [MODE_SPLIT, FREE_RUN]");
   end
   if (!(N60_LO - EQ_OFFSET > ATF_END_60 && N60_LO >= WIDE_LO + EQ_OFFSET)) begin : g_bad_eq
      $error("vsync_divider: flutter start point out of range");
   end
   if (!(UNLOCK_BELOW > 0 && UNLOCK_BELOW <= CONF_MAX && CONF_MAX > 0)) begin : g_bad_conf
      $error("vsync_divider: confidence thresholds inconsistent");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             sync_evt;
   logic             wide_ok, in_lock, win_end, eq_hit, atf_end_hit;
   logic             accept, forced, fire;
   logic             conf_up, conf_down;
   logic             atf_start, atf_stop;
   logic             lock;
   logic             vreset_q, field_60_q;

   // sync qualification variant
   if (SYNC_EDGE != 0) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            prev_q <= 1'b0;
         else if (tick)
            prev_q <= vsync;
      end
      assign sync_evt = vsync && !prev_q;
   end else begin : g_level
      assign sync_evt = vsync;
   end

   vsd_window_decode #(
      .WIDE_LO    (WIDE_LO),
      .FREE_RUN   (FREE_RUN),
      .N60_LO     (N60_LO),
      .N60_HI     (N60_HI),
      .N50_LO     (N50_LO),
      .N50_HI     (N50_HI),
      .EQ_OFFSET  (EQ_OFFSET),
      .ATF_END_50 (ATF_END_50),
      .ATF_END_60 (ATF_END_60),
      .CNT_W      (CNT_W)
   ) u_dec (
      .cnt         (cnt_q),
      .narrow      (lock),
      .field_60    (field_60_q),
      .wide_ok     (wide_ok),
      .in_lock     (in_lock),
      .win_end     (win_end),
      .eq_hit      (eq_hit),
      .atf_end_hit (atf_end_hit)
   );

   always_comb begin
      accept    = tick && sync_evt && (lock ? in_lock : wide_ok);
      forced    = tick && !accept && win_end;
      fire      = accept || forced;
      conf_up   = accept && in_lock;
      conf_down = (accept && !in_lock) || forced;
      atf_start = (fire && !lock) || (tick && lock && eq_hit);
      atf_stop  = tick && atf_end_hit;
   end

   vsd_confidence #(
      .CONF_MAX     (CONF_MAX),
      .UNLOCK_BELOW (UNLOCK_BELOW),
      .CONF_W       (CONF_W)
   ) u_conf (
      .clk   (clk),
      .rst_n (rst_n),
      .up    (conf_up),
      .down  (conf_down),
      .conf  (confidence),
      .lock  (lock)
   );

   vsd_flutter u_atf (
      .clk   (clk),
      .rst_n (rst_n),
      .start (atf_start),
      .stop  (atf_stop),
      .blank (flutter_blank)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q      <= CNT_ONE;
         vreset_q   <= 1'b0;
         field_60_q <= 1'b0;
      end else if (tick) begin
         cnt_q    <= fire ? CNT_ONE : cnt_q + CNT_ONE;
         vreset_q <= fire;
         if (accept && !lock)
            field_60_q <= (cnt_q < SPLIT);
      end
   end

   assign vreset      = vreset_q;
   assign field_60    = field_60_q;
   assign lock_narrow = lock;

endmodule

// File: rtl/vsync_divider_chk.sv
module vsync_divider_chk #(
   parameter int unsigned CONF_MAX     = 15,
   parameter int unsigned UNLOCK_BELOW = 10,
   parameter int unsigned CONF_W       = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              vreset,
   input logic              field_60,
   input logic              lock_narrow,
   input logic              flutter_blank,
   input logic [CONF_W-1:0] confidence
);

   localparam logic [CONF_W-1:0] TOP  = CONF_W'(CONF_MAX);
   localparam logic [CONF_W-1:0] ONE  = CONF_W'(1);
   localparam logic [CONF_W-1:0] DROP = CONF_W'(UNLOCK_BELOW);

   // R5: single steps, no wrap past either end
   assert_conf_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(confidence) |->
         ((confidence == $past(confidence) + ONE) && ($past(confidence) != TOP)) ||
         ((confidence + ONE == $past(confidence)) && ($past(confidence) != '0)));

   // R5: confidence only moves together with a divider reset
   assert_conf_at_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(confidence) |-> vreset);

   // R6: lock entered only at full confidence
   assert_lock_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_narrow) |-> (confidence == TOP));

   // R6: lock left only below the release threshold
   assert_lock_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lock_narrow) |-> (confidence < DROP));

   // R3: rate flag moves only with a reset strobe
   assert_rate_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(field_60) |-> vreset);

   // R11: strobe lasts a single tick period
   assert_strobe_width_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (vreset && tick) |=> !vreset);

   // R11: nothing changes without a tick
   assert_tick_gating_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> ($stable(vreset) && $stable(field_60) && $stable(lock_narrow) &&
                 $stable(flutter_blank) && $stable(confidence)));

endmodule

bind vsync_divider vsync_divider_chk #(
   .CONF_MAX     (CONF_MAX),
   .UNLOCK_BELOW (UNLOCK_BELOW),
   .CONF_W       (CONF_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .tick          (tick),
   .vreset        (vreset),
   .field_60      (field_60),
   .lock_narrow   (lock_narrow),
   .flutter_blank (flutter_blank),
   .confidence    (confidence)
);

// File: tb/vsync_divider_test.sv
module vsync_divider_test;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       tick;
   logic       vsync;
   logic       vreset, field_60, lock_narrow, flutter_blank;
   logic [3:0] confidence;

   always #2 clk = ~clk;

   vsync_divider uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .tick          (tick),
      .vsync         (vsync),
      .vreset        (vreset),
      .field_60      (field_60),
      .lock_narrow   (lock_narrow),
      .flutter_blank (flutter_blank),
      .confidence    (confidence)
   );

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   // requirement-level reference state
   int m_cnt = 1, m_conf = 0, m_narrow = 0, m_60 = 0, m_atf = 0, m_vr = 0, m_prev = 0;
   // observations taken at the ports
   int ticks_since = 0, last_period = 0, flut_run = 0, last_flutter = 0;

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d (time %0t)", req, what, act, exp, $time);
      end
   endtask

   task automatic compare_all(input string tag);
      chk({tag, " R2"},  "vreset",        int'(vreset),        m_vr);
      chk({tag, " R3"},  "field_60",      int'(field_60),      m_60);
      chk({tag, " R6"},  "lock_narrow",   int'(lock_narrow),   m_narrow);
      chk({tag, " R9"},  "flutter_blank", int'(flutter_blank), m_atf);
      chk({tag, " R5"},  "confidence",    int'(confidence),    m_conf);
   endtask

   task automatic model_tick(input bit s);
      int c, lo, hi, endc;
      bit evt, acc, frc, inw, rst;
      evt    = s && (m_prev == 0);
      m_prev = s;
      c      = m_cnt;
      lo     = m_60 ? 522 : 622;
      hi     = m_60 ? 528 : 628;
      endc   = m_60 ? 12 : 10;
      if (m_narrow == 0) begin
         acc = evt && (c >= 488);
         inw = ((c >= 522) && (c <= 528)) || ((c >= 622) && (c <= 628));
         frc = !acc && (c >= 630);
      end else begin
         acc = evt && (c >= lo) && (c <= hi);
         inw = 1;
         frc = !acc && (c == hi);
      end
      rst = acc || frc;
      if ((rst && m_narrow == 0) || (m_narrow == 1 && c == lo - 3)) m_atf = 1;
      else if (c == endc) m_atf = 0;
      if (acc && m_narrow == 0) m_60 = (c < 576) ? 1 : 0;
      if (acc && inw) begin
         if (m_conf < 15) m_conf++;
      end else if (rst) begin
         if (m_conf > 0) m_conf--;
      end
      if (m_narrow == 0 && m_conf == 15) m_narrow = 1;
      else if (m_narrow == 1 && m_conf < 10) m_narrow = 0;
      m_cnt = rst ? 1 : c + 1;
      m_vr  = rst ? 1 : 0;
   endtask

   task automatic step(input bit s);
      @(negedge clk);
      compare_all("R11 idle");
      tick  = 1'b1;
      vsync = s;
      @(posedge clk);
      model_tick(s);
      @(negedge clk);
      tick = 1'b0;
      compare_all("tick");
      ticks_since++;
      if (vreset) begin
         last_period = ticks_since;
         ticks_since = 0;
      end
      if (flutter_blank) flut_run++;
      else if (flut_run > 0) begin
         last_flutter = flut_run;
         flut_run     = 0;
      end
   endtask

   task automatic sync_at(input int p);
      while (m_cnt != p) step(1'b0);
      step(1'b1);
   endtask

   task automatic until_reset();
      step(1'b0);
      while (m_vr == 0) step(1'b0);
   endtask

   task automatic idle_ticks(input int n);
      for (int i = 0; i < n; i++) step(1'b0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      tick  = 1'b0;
      vsync = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1", "vreset",        int'(vreset),        0);
      chk("R1", "field_60",      int'(field_60),      0);
      chk("R1", "lock_narrow",   int'(lock_narrow),   0);
      chk("R1", "flutter_blank", int'(flutter_blank), 0);
      chk("R1", "confidence",    int'(confidence),    0);

      // R4: no signal, free-running fields
      idle_ticks(1300);
      chk("R4",  "free-run period",         last_period,  630);
      chk("R10", "wide 50 Hz blank length", last_flutter, 10);

      // 50 Hz standard fields climb to lock
      for (int f = 0; f < 14; f++) sync_at(625);
      chk("R5", "confidence after 14 fields", int'(confidence), 14);
      chk("R6", "still wide at 14",           int'(lock_narrow), 0);
      sync_at(625);
      chk("R6", "lock at 15",                 int'(lock_narrow), 1);
      chk("R3", "50 Hz detected",             int'(field_60),   0);
      chk("R2", "accepted period",            last_period,      625);
      sync_at(625);
      idle_ticks(20);
      chk("R7", "lock field period",          last_period,      625);
      chk("R9", "lock 50 Hz blank length",    last_flutter,     16);

      // R7/R8: sync outside the window ignored, window-end reset
      sync_at(600);
      until_reset();
      chk("R8", "missing-pulse period",       last_period,      628);
      chk("R7", "outside pulse ignored conf", int'(confidence), 14);
      for (int f = 0; f < 4; f++) until_reset();
      chk("R6", "hysteresis holds at 10",     int'(lock_narrow), 1);
      chk("R8", "conf after misses",          int'(confidence), 10);
      until_reset();
      chk("R6", "lock lost at 9",             int'(lock_narrow), 0);

      // 60 Hz standard
      sync_at(525);
      chk("R3", "60 Hz detected",             int'(field_60),   1);
      sync_at(525);
      chk("R10", "wide 60 Hz blank length",   last_flutter,     12);
      for (int f = 0; f < 4; f++) sync_at(525);
      chk("R6", "60 Hz lock",                 int'(lock_narrow), 1);
      sync_at(525);
      sync_at(525);
      idle_ticks(20);
      chk("R9", "lock 60 Hz blank length",    last_flutter,     18);
      for (int f = 0; f < 6; f++) until_reset();
      chk("R8", "60 Hz window end period",    last_period,      528);
      chk("R6", "wide again",                 int'(lock_narrow), 0);

      // wide mode, off-standard periods
      sync_at(560);
      chk("R3", "560 counts as 60 Hz",        int'(field_60),   1);
      chk("R5", "off-window decrement",       int'(confidence), 8);
      sync_at(590);
      chk("R3", "590 counts as 50 Hz",        int'(field_60),   0);
      sync_at(300);
      sync_at(500);
      chk("R2", "early pulse ignored",        last_period,      500);

      // R12: level held high from before the acceptance point
      while (m_cnt != 480) step(1'b0);
      for (int i = 0; i < 30; i++) step(1'b1);
      until_reset();
      chk("R12", "held level counts once",    last_period,      630);

      // R5: saturation at zero
      for (int f = 0; f < 8; f++) sync_at(560);
      chk("R5", "confidence floor",           int'(confidence), 0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule